// File: doc/BRIEF.md
# Multiplexed Strobe Bus Register Slave

This block sits inside an FPGA and answers a slow host that bit-bangs an 8-bit bus shared between address and data. Three active-high strobes come with the bus. One latches an address, one writes a byte and one reads a byte. The host changes these strobes with no timing relation to the FPGA clock. The block passes each strobe through a chain of flip-flops and finds its edges in the fast clock domain. It samples the data lines directly on those edges, because the host keeps the data steady for about a microsecond on either side of every strobe.

A latched address selects one entry of an internal file of bytes. A write pulse stores the bus byte at that entry. While the read strobe is high, the block drives the stored byte onto the bus. The pad is split into an input, an output and an output enable.

Top module: `mux_bus_slave`

## Requirements
- R1: While reset is held and on the first cycle after it, `bus_oe` is 0 and `bus_out` is 0x00.
- R2: A rising edge on `ale_in` stores the value on `bus_in` as the current address. Any other bus activity leaves the address unchanged.
- R3: A rising edge on `wr_in` stores `bus_in` into the register at the current address. A later read of that address returns the stored byte.
- R4: Each `wr_in` pulse writes exactly once, using the bus value present at its rising edge. Changes on the bus while `wr_in` stays high have no effect.
- R5: `bus_oe` is 1 only while a read is in progress. It returns to 0 within 4 clock cycles after `rd_in` falls.
- R6: A write or read issued with no `ale_in` pulse since reset uses address 0x00.
- R7: Reset clears all 256 registers to 0x00, so an address that has never been written reads back 0x00.
- R8: `bus_oe` and valid `bus_out` appear no earlier than 2 and no later than 4 clock cycles after `rd_in` rises. This allows for the two-flop synchronizer and one output register.
- R9: The address stays in force across several write or read pulses until the next `ale_in` pulse. Two writes in a row to one address leave the second value there.
- R10: Changing `bus_in` with no strobe active changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast FPGA clock |
| rst | input | 1 | Synchronous active-high reset |
| ale_in | input | 1 | Asynchronous address-latch strobe, active high |
| rd_in | input | 1 | Asynchronous read strobe, active high |
| wr_in | input | 1 | Asynchronous write strobe, active high |
| bus_in | input | 8 | Bus value seen at the pad |
| bus_out | output | 8 | Byte driven to the pad during a read |
| bus_oe | output | 1 | Pad output enable, high only during a read |

## Verification
A stale or corrupted address register appears at the ports as a read that returns another address's byte. It shows on the very next read pulse. A write that fires on the wrong edge, or fires more than once, leaves a byte that differs from the one present at the write's rising edge. Any later read-back of that address exposes it. A fault in the output-enable path is visible within a few cycles of a read strobe edge, through `bus_oe` rising early or staying high once the read has ended.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } mbs_state_t;

  localparam int unsigned STB_ALE = 0;
  localparam int unsigned STB_WR  = 1;
  localparam int unsigned STB_RD  = 2;
  localparam int unsigned STB_N   = 3;
endpackage

// File: rtl/mbs_strobe_sync.sv
module mbs_strobe_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned N      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
        prev  <= chain[STAGES-1];
      end
    end
    assign level[g] = chain[STAGES-1];
    assign rise[g]  = chain[STAGES-1] & ~prev;
    assign fall[g]  = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_rise,
  input  logic              wr_rise,
  input  logic              wr_fall,
  input  logic              rd_rise,
  input  logic              rd_fall,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] addr,
  output logic              we,
  output logic [DATA_W-1:0] wdata
);
  mbs_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_ADDR: begin
        if (ale_rise)     state_d = ST_ADDR;
        else if (wr_rise) state_d = ST_WRITE;
        else if (rd_rise) state_d = ST_READ;
      end
      ST_WRITE: if (wr_fall) state_d = ST_ADDR;
      ST_READ:  if (rd_fall) state_d = ST_ADDR;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr    <= '0;
      we      <= 1'b0;
      wdata   <= '0;
    end else begin
      state_q <= state_d;
      if (ale_rise && state_q != ST_READ) addr <= bus_in;
      we <= wr_rise && !ale_rise && state_q != ST_READ;
      if (wr_rise) wdata <= bus_in;
    end
  end
endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import mbs_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_in,
  input  logic              rd_in,
  input  logic              wr_in,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  localparam int unsigned ADDR_W = DATA_W;

  logic [STB_N-1:0]  stb_raw, stb_lvl, stb_rise, stb_fall;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata, rdata;
  logic              we;
  logic              rd_lvl, ale_rise;

  always_comb begin
    stb_raw          = '0;
    stb_raw[STB_ALE] = ale_in;
    stb_raw[STB_WR]  = wr_in;
    stb_raw[STB_RD]  = rd_in;
  end

  mbs_strobe_sync #(.STAGES(SYNC_STAGES), .N(STB_N)) u_sync (
    .clk(clk), .rst(rst), .raw(stb_raw),
    .level(stb_lvl), .rise(stb_rise), .fall(stb_fall)
  );

  assign rd_lvl   = stb_lvl[STB_RD];
  assign ale_rise = stb_rise[STB_ALE];

  mbs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .ale_rise(ale_rise),
    .wr_rise(stb_rise[STB_WR]), .wr_fall(stb_fall[STB_WR]),
    .rd_rise(stb_rise[STB_RD]), .rd_fall(stb_fall[STB_RD]),
    .bus_in(bus_in), .addr(addr_q), .we(we), .wdata(wdata)
  );

  mbs_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst(rst), .we(we), .addr(addr_q),
    .wdata(wdata), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      bus_oe  <= rd_lvl;
      bus_out <= rd_lvl ? rdata : '0;
    end
  end
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_in,
  input logic              bus_oe,
  input logic              rd_sync,
  input logic              ale_rise,
  input logic [ADDR_W-1:0] addr,
  input logic              we
);
  // R1: output enable is low right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) rst |=> !bus_oe);

  // R2: the address only moves on a detected address-latch edge
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !ale_rise |=> $stable(addr));

  // R4: a write enable never lasts two cycles
  a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);

  // R5: the pad is released after the synchronized read ends
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_sync) |=> !bus_oe);

  // R8: output enable never leads the raw read strobe by less than two edges
  a_r8_oe_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> ($past(rd_in, 1) && $past(rd_in, 2)));
endmodule

bind mux_bus_slave mbs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_in(rd_in), .bus_oe(bus_oe),
  .rd_sync(rd_lvl), .ale_rise(ale_rise), .addr(addr_q), .we(we)
);

// File: tb/tb_mux_bus_slave.sv
module tb_mux_bus_slave;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale_in = 1'b0, rd_in = 1'b0, wr_in = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mux_bus_slave dut (
    .clk(clk), .rst(rst), .ale_in(ale_in), .rd_in(rd_in), .wr_in(wr_in),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_addr(input logic [7:0] a);
    bus_in = a; wait_n(3);
    ale_in = 1'b1; wait_n(6);
    ale_in = 1'b0; wait_n(3);
  endtask

  task automatic do_write(input logic [7:0] d);
    bus_in = d; wait_n(3);
    wr_in = 1'b1; wait_n(6);
    wr_in = 1'b0; wait_n(3);
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    bus_in = 8'hzz;
    rd_in = 1'b1; wait_n(6);
    check({req, " oe during read"}, bus_oe, 1'b1);
    check({req, " read data"}, bus_out, exp);
    rd_in = 1'b0; wait_n(5);
    check("R5 oe released", bus_oe, 1'b0);
  endtask

  task automatic t_reset;
    wait_n(1);
    check("R1 oe in reset", bus_oe, 1'b0);
    check("R1 out in reset", bus_out, 8'h00);
    rst = 1'b0; wait_n(1);
    check("R1 oe after reset", bus_oe, 1'b0);
    check("R1 out after reset", bus_out, 8'h00);
  endtask

  task automatic t_no_ale;
    do_read("R7 R6 cleared addr0", 8'h00);
    do_write(8'h5A);
    do_read("R6 write without ALE", 8'h5A);
    do_addr(8'h00);
    do_read("R6 addr0 via ALE", 8'h5A);
  endtask

  task automatic t_basic;
    do_addr(8'hFF); do_write(8'hC3);
    do_addr(8'h80); do_write(8'h01);
    do_addr(8'h07); do_write(8'hA5);
    do_addr(8'hFF); do_read("R3 R2 addr FF", 8'hC3);
    do_addr(8'h80); do_read("R3 R2 addr 80", 8'h01);
    do_addr(8'h07); do_read("R3 R2 addr 07", 8'hA5);
    do_addr(8'h33); do_read("R7 unwritten", 8'h00);
  endtask

  task automatic t_long_write;
    do_addr(8'h10);
    bus_in = 8'h11; wait_n(3);
    wr_in = 1'b1; wait_n(6);
    bus_in = 8'h22; wait_n(20);
    bus_in = 8'h33; wait_n(10);
    wr_in = 1'b0; wait_n(3);
    do_read("R4 long pulse", 8'h11);
  endtask

  task automatic t_sticky_addr;
    do_addr(8'h20);
    do_write(8'h01);
    do_write(8'h02);
    do_read("R9 second write wins", 8'h02);
    do_read("R9 repeat read", 8'h02);
    do_addr(8'h21);
    do_read("R9 neighbour untouched", 8'h00);
  endtask

  task automatic t_idle_bus;
    do_addr(8'h20);
    for (int i = 0; i < 8; i++) begin
      bus_in = 8'(i * 37); wait_n(2);
    end
    do_read("R10 idle bus", 8'h02);
  endtask

  task automatic t_latency;
    do_addr(8'h07);
    bus_in = 8'hzz;
    rd_in = 1'b1; wait_n(1);
    check("R8 oe not early", bus_oe, 1'b0);
    wait_n(3);
    check("R8 oe by 4 cycles", bus_oe, 1'b1);
    check("R8 data by 4 cycles", bus_out, 8'hA5);
    rd_in = 1'b0; wait_n(4);
    check("R5 released in 4 cycles", bus_oe, 1'b0);
  endtask

  initial begin
    t_reset();
    t_no_ale();
    t_basic();
    t_long_write();
    t_sticky_addr();
    t_idle_bus();
    t_latency();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule